// File: doc/BRIEF.md
# Reloadable Down-Counter Timer Channel

This block is one channel of a general-purpose timer. It holds a counter, a reload value and a small control/status register. On every cycle where the shared prescaler strobe is high and the channel is enabled, the counter steps down by one. The channel expires when the counter would pass below zero, so a loaded value N lasts N+1 prescaler ticks.

On expiry the channel can raise a sticky pending flag and emit a single-cycle interrupt pulse. It can also either reload itself from the reload register and keep running, or stop.

Software reaches the three registers through per-register write strobes that share one data bus, and through a read select. The address decoding and the prescaler itself live outside the channel.

Top module: `rld_timer_chan`

## Requirements
- R1: After reset the counter, the reload register and every control field read zero, and `irqPulse` is low.
- R2: The control word layout is: bit 0 enable, bit 1 auto-restart, bit 2 load (a command), bit 3 interrupt enable, bit 4 pending. A control write stores bits 0, 1 and 3. Bit 2 and bits 5 and above always read zero. The read select encoding is 0 counter, 1 reload, 2 control, 3 constant zero.
- R3: The counter changes only on a cycle where `tick` is high and enable is set. Any other cycle leaves it unchanged.
- R4: A counter holding N reaches zero after N enabled ticks and expires on tick N+1. Reaching zero alone does not expire the channel.
- R5: On expiry with interrupt enable set, pending becomes 1 and `irqPulse` is high for exactly the one cycle after the expiring edge. With interrupt enable clear, neither changes.
- R6: On expiry with auto-restart set, the counter takes the reload value and counting continues.
- R7: On expiry with auto-restart clear, the counter stays at zero and the enable bit clears, unless a control write lands in the same cycle.
- R8: A control write with bit 2 set copies the reload register into the counter, whether or not enable is set in that write.
- R9: Writing 1 to pending clears it and writing 0 keeps it. An expiry in the same cycle as a clearing write leaves pending set.
- R10: A counter write loads the data directly and takes precedence over a tick or a load in the same cycle. Counting resumes from the written value if enabled.
- R11: A reload register write does not change the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Prescaler tick strobe |
| wrCount | input | 1 | Write strobe for the counter register |
| wrReload | input | 1 | Write strobe for the reload register |
| wrControl | input | 1 | Write strobe for the control register |
| wrData | input | 32 | Write data shared by the three strobes |
| rdSel | input | 2 | Read select: 0 counter, 1 reload, 2 control, 3 zero |
| rdData | output | 32 | Read data for the selected register |
| irqPulse | output | 1 | One-cycle interrupt pulse on expiry |

## Verification
The countdown is exercised in several ways:
- Gated and ungated tick trains show that neither idle cycles nor a disabled channel move the counter.
- A one-shot run from a small value separates expiry at underflow from expiry at zero, because the pulse must appear on the tick after the counter shows zero.
- Auto-restart runs repeated twice show the reload path and the repeated pulses.
- Colliding stimuli check the priority rules that a plain sequence cannot reach: a counter write together with a tick, and a pending-clear write in the expiring cycle.
- Pending is written with 0 and with 1 to separate "keep" from "clear".

// File: rtl/rld_timer_pkg.sv
package rld_timer_pkg;
  localparam int CTL_EN_BIT   = 0;
  localparam int CTL_RST_BIT  = 1;
  localparam int CTL_LOAD_BIT = 2;
  localparam int CTL_IE_BIT   = 3;
  localparam int CTL_PEND_BIT = 4;
  localparam int CTL_FIELDS   = 5;

  localparam logic [1:0] SEL_COUNT   = 2'd0;
  localparam logic [1:0] SEL_RELOAD  = 2'd1;
  localparam logic [1:0] SEL_CONTROL = 2'd2;

  typedef struct packed {
    logic wrCount;
    logic loadReload;
    logic decrement;
  } cntStrobes_t;
endpackage

// File: rtl/rld_timer_ctrl.sv
module rld_timer_ctrl
  import rld_timer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  tick,
  input  logic                  wrCount,
  input  logic                  wrControl,
  input  logic [DATA_W-1:0]     wrData,
  input  logic                  cntZero,
  output cntStrobes_t           strobes,
  output logic [CTL_FIELDS-1:0] ctlWord,
  output logic                  irqPulse
);
  logic ctlEn, ctlRst, ctlIe, ctlPend;
  logic expire, ctlLoad, clearPend;

  assign expire    = tick && ctlEn && cntZero;
  assign ctlLoad   = wrControl && wrData[CTL_LOAD_BIT];
  assign clearPend = wrControl && wrData[CTL_PEND_BIT];

  always_comb begin
    strobes = '0;
    if (wrCount) begin
      strobes.wrCount = 1'b1;
    end else if (ctlLoad) begin
      strobes.loadReload = 1'b1;
    end else if (tick && ctlEn) begin
      if (cntZero) strobes.loadReload = ctlRst;
      else         strobes.decrement  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlEn    <= 1'b0;
      ctlRst   <= 1'b0;
      ctlIe    <= 1'b0;
      ctlPend  <= 1'b0;
      irqPulse <= 1'b0;
    end else begin
      if (wrControl) begin
        ctlEn  <= wrData[CTL_EN_BIT];
        ctlRst <= wrData[CTL_RST_BIT];
        ctlIe  <= wrData[CTL_IE_BIT];
      end else if (expire && !ctlRst) begin
        ctlEn <= 1'b0;
      end
      if (expire && ctlIe)  ctlPend <= 1'b1;
      else if (clearPend)   ctlPend <= 1'b0;
      irqPulse <= expire && ctlIe;
    end
  end

  always_comb begin
    ctlWord               = '0;
    ctlWord[CTL_EN_BIT]   = ctlEn;
    ctlWord[CTL_RST_BIT]  = ctlRst;
    ctlWord[CTL_IE_BIT]   = ctlIe;
    ctlWord[CTL_PEND_BIT] = ctlPend;
  end

  // R5: a pulse always comes with the pending flag
  p_irq_sets_pend_r5: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> ctlPend);
  // R4: a pulse only follows a tick seen at a zero count
  p_irq_after_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> $past(tick && cntZero));
  // R9: pending holds unless cleared by a write of one
  p_pend_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ctlPend && !clearPend) |=> ctlPend);
  // R7: one-shot expiry stops the channel
  p_oneshot_stops_r7: assert property (@(posedge clk) disable iff (!rstN)
    (expire && !ctlRst && !wrControl) |=> !ctlEn);
endmodule

// File: rtl/rld_timer_dpath.sv
module rld_timer_dpath
  import rld_timer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrReload,
  input  logic [DATA_W-1:0]     wrData,
  input  cntStrobes_t           strobes,
  input  logic [CTL_FIELDS-1:0] ctlWord,
  input  logic [1:0]            rdSel,
  output logic                  cntZero,
  output logic [DATA_W-1:0]     rdData
);
  logic [DATA_W-1:0] count, reloadVal;

  assign cntZero = (count == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count     <= '0;
      reloadVal <= '0;
    end else begin
      if (strobes.wrCount)         count <= wrData;
      else if (strobes.loadReload) count <= reloadVal;
      else if (strobes.decrement)  count <= count - 1'b1;
      if (wrReload) reloadVal <= wrData;
    end
  end

  always_comb begin
    rdData = '0;
    case (rdSel)
      SEL_COUNT:   rdData = count;
      SEL_RELOAD:  rdData = reloadVal;
      SEL_CONTROL: rdData[CTL_FIELDS-1:0] = ctlWord;
      default:     rdData = '0;
    endcase
  end

  // R10: the control side issues at most one counter action per cycle
  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.wrCount, strobes.loadReload, strobes.decrement}));
  // R3: with no action the counter holds
  p_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes == '0) |=> $stable(count));
  // R6: a reload takes the reload value of that cycle
  p_reload_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadReload |=> (count == $past(reloadVal)));
endmodule

// File: rtl/rld_timer_chan.sv
module rld_timer_chan
  import rld_timer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              wrCount,
  input  logic              wrReload,
  input  logic              wrControl,
  input  logic [DATA_W-1:0] wrData,
  input  logic [1:0]        rdSel,
  output logic [DATA_W-1:0] rdData,
  output logic              irqPulse
);
  cntStrobes_t           strobes;
  logic [CTL_FIELDS-1:0] ctlWord;
  logic                  cntZero;

  rld_timer_ctrl #(.DATA_W(DATA_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .wrCount(wrCount),
    .wrControl(wrControl), .wrData(wrData), .cntZero(cntZero),
    .strobes(strobes), .ctlWord(ctlWord), .irqPulse(irqPulse)
  );

  rld_timer_dpath #(.DATA_W(DATA_W)) i_dpath (
    .clk(clk), .rstN(rstN), .wrReload(wrReload), .wrData(wrData),
    .strobes(strobes), .ctlWord(ctlWord), .rdSel(rdSel),
    .cntZero(cntZero), .rdData(rdData)
  );
endmodule

// File: tb/test_rld_timer_chan.sv
module test_rld_timer_chan;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0, wrCount = 1'b0, wrReload = 1'b0, wrControl = 1'b0;
  logic [31:0] wrData = '0;
  logic [1:0]  rdSel = '0;
  logic [31:0] rdData;
  logic        irqPulse;
  int          nChecks = 0, nFails = 0;

  always #5 clk = ~clk;

  rld_timer_chan i_rld_timer_chan (
    .clk(clk), .rstN(rstN), .tick(tick), .wrCount(wrCount),
    .wrReload(wrReload), .wrControl(wrControl), .wrData(wrData),
    .rdSel(rdSel), .rdData(rdData), .irqPulse(irqPulse)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  // one cycle of stimulus, driven at negedge; returns just after the next negedge
  task automatic cyc(input logic t, input logic wc, input logic wr, input logic wk,
                     input logic [31:0] d);
    @(negedge clk);
    tick = t; wrCount = wc; wrReload = wr; wrControl = wk; wrData = d;
    @(negedge clk);
    tick = 0; wrCount = 0; wrReload = 0; wrControl = 0; wrData = '0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1, 0, 0, 0, '0);
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] v);
    rdSel = s; #1; v = rdData;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(0, v); chk("R1 counter", v, 0);
    rd(1, v); chk("R1 reload", v, 0);
    rd(2, v); chk("R1 control", v, 0);
    rd(3, v); chk("R2 sel3", v, 0);
    chk("R1 irq", irqPulse, 0);
  endtask

  task automatic t_fields;
    logic [31:0] v;
    cyc(0, 0, 0, 1, 32'hFFFF_FFFF);
    rd(2, v); chk("R2 field mask", v, 32'h0B);
    cyc(0, 0, 0, 1, 0);
    rd(2, v); chk("R2 cleared", v, 0);
  endtask

  task automatic t_gate;
    logic [31:0] v;
    cyc(0, 1, 0, 0, 5);
    ticks(3);
    rd(0, v); chk("R3 disabled ticks", v, 5);
    cyc(0, 0, 0, 1, 32'h1);
    repeat (3) cyc(0, 0, 0, 0, 0);
    rd(0, v); chk("R3 no tick", v, 5);
    ticks(2);
    rd(0, v); chk("R3 two ticks", v, 3);
  endtask

  task automatic t_underflow;
    logic [31:0] v;
    cyc(0, 1, 0, 0, 2);
    cyc(0, 0, 0, 1, 32'h9);
    ticks(2);
    rd(0, v); chk("R4 at zero", v, 0);
    chk("R4 no irq at zero", irqPulse, 0);
    rd(2, v); chk("R4 no pend at zero", v, 32'h9);
    ticks(1);
    chk("R5 irq pulse", irqPulse, 1);
    rd(2, v); chk("R7 stopped, R5 pend", v, 32'h18);
    cyc(0, 0, 0, 0, 0);
    chk("R5 pulse one cycle", irqPulse, 0);
    rd(0, v); chk("R7 count stays zero", v, 0);
    ticks(2);
    rd(0, v); chk("R7 stays stopped", v, 0);
  endtask

  task automatic t_pend;
    logic [31:0] v;
    cyc(0, 0, 0, 1, 32'h0);
    rd(2, v); chk("R9 write0 keeps", v, 32'h10);
    cyc(0, 0, 0, 1, 32'h10);
    rd(2, v); chk("R9 write1 clears", v, 0);
  endtask

  task automatic t_noie;
    logic [31:0] v;
    cyc(0, 1, 0, 0, 0);
    cyc(0, 0, 0, 1, 32'h1);
    ticks(1);
    chk("R5 no irq without ie", irqPulse, 0);
    rd(2, v); chk("R5 no pend without ie", v, 0);
  endtask

  task automatic t_restart;
    logic [31:0] v;
    cyc(0, 0, 1, 0, 3);
    cyc(0, 0, 0, 1, 32'h0F);
    rd(0, v); chk("R8 load copies reload", v, 3);
    rd(2, v); chk("R2 load reads zero", v, 32'h0B);
    for (int k = 0; k < 2; k++) begin
      ticks(3);
      chk("R4 no early irq", irqPulse, 0);
      ticks(1);
      chk("R6 irq on restart", irqPulse, 1);
      rd(0, v); chk("R6 reloaded", v, 3);
    end
    cyc(0, 0, 0, 1, 32'h1B);
    rd(2, v); chk("R9 clear keeps fields", v, 32'h0B);
    cyc(0, 0, 0, 1, 0);
  endtask

  task automatic t_load_disabled;
    logic [31:0] v;
    cyc(0, 0, 1, 0, 7);
    cyc(0, 0, 0, 1, 32'h4);
    rd(0, v); chk("R8 load while disabled", v, 7);
    rd(2, v); chk("R8 control after load", v, 0);
    cyc(0, 0, 1, 0, 100);
    rd(0, v); chk("R11 reload write no effect", v, 7);
    rd(1, v); chk("R11 reload stored", v, 100);
  endtask

  task automatic t_cnt_prio;
    logic [31:0] v;
    cyc(0, 0, 0, 1, 32'h1);
    cyc(1, 1, 0, 0, 9);
    rd(0, v); chk("R10 write beats tick", v, 9);
    ticks(1);
    rd(0, v); chk("R10 resumes", v, 8);
  endtask

  task automatic t_clear_vs_expire;
    logic [31:0] v;
    cyc(0, 1, 0, 0, 0);
    cyc(0, 0, 0, 1, 32'h9);
    cyc(1, 0, 0, 1, 32'h19);
    chk("R9 irq in collision", irqPulse, 1);
    rd(2, v); chk("R9 expiry beats clear", v, 32'h19);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_fields();
    t_gate();
    t_underflow();
    t_pend();
    t_noie();
    t_restart();
    t_load_disabled();
    t_cnt_prio();
    t_clear_vs_expire();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #200000;
    nChecks++; nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule